// File: doc/BRIEF.md
# I2C Address-Phase Status Tracker

This block keeps the three status flags that a two-wire serial interface reports while the first byte after a START is on the bus, and for the rest of that transfer. The flags say whether that byte was an extension code, whether it carried this device's own address, and whether the device is now the transmitting side. The block also tells the pad logic when the device may drive SDA.

The block takes single-cycle event pulses from a bus front end: START seen, STOP seen, SCL rising, SCL falling, and arbitration lost. Each SCL rising pulse carries the sampled SDA value. It also takes control pulses: leave the transfer, and release the wait. An enable level, a master/slave select and the 7-bit local address complete the inputs. An internal counter finds the address byte. Each flag is updated on the clock edge that samples the event causing the change.

Top module: `i2c_addr_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, `flag_ext`, `flag_match`, `flag_tx` and `sda_oe` are all 0 after that edge.
- R2: On the SCL rising pulse of the 8th bit after a START, `flag_ext` becomes 1 if the first four bits of that byte (received MSB first) are 0000 or 1111.
- R3: On the same pulse, `flag_match` becomes 1 if bits 1 to 7 of the byte (MSB first) equal `local_addr`.
- R4: `flag_ext` and `flag_match` go to 0 on `ev_start`, `ev_stop`, `exit_req`, or a 1-to-0 change of `enable`.
- R5: In master mode (`is_master`=1), `ev_start` sets `flag_tx`. On the 8th-bit rising pulse the flag stays 1 if the bit is 0 (write) and goes to 0 if the bit is 1 (read).
- R6: In slave mode, `ev_start` clears `flag_tx`. If the 8th-bit pulse also sets `flag_ext` or `flag_match`, `flag_tx` takes the value of the 8th bit.
- R7: A slave with neither `flag_ext` nor `flag_match` set keeps `flag_tx` at 0.
- R8: `flag_tx` goes to 0 on `ev_stop`, `exit_req`, `wait_release`, a 0-to-1 change of `arb_lost`, or a 1-to-0 change of `enable`.
- R9: `sda_oe` is 1 only while `flag_tx` is 1 and the SCL falling pulse that ends the 9th clock of the first byte has already occurred.
- R10: If a clearing event and a setting event arrive in the same cycle, the flag ends up 0.
- R11: After the 9th clock of the first byte, further SCL pulses do not change any flag until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Interface enable level |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| local_addr | input | 7 | Own slave address |
| ev_start | input | 1 | START detected or generated (pulse) |
| ev_stop | input | 1 | STOP detected (pulse) |
| scl_rise | input | 1 | SCL rising edge (pulse); `sda_in` is sampled with it |
| scl_fall | input | 1 | SCL falling edge (pulse) |
| sda_in | input | 1 | SDA value at the SCL rising edge |
| arb_lost | input | 1 | Arbitration-lost level; its rising edge counts |
| exit_req | input | 1 | Leave the current transfer (pulse) |
| wait_release | input | 1 | Wait release (pulse) |
| flag_ext | output | 1 | Extension code received |
| flag_match | output | 1 | Local address matched |
| flag_tx | output | 1 | Transmit status |
| sda_oe | output | 1 | SDA driver enable |

## Verification
A wrong bit count or a wrong shift shows up on the flags at the 8th-bit rising pulse, one cycle after it, as a missed or spurious `flag_ext` or `flag_match`. A direction flag in the wrong state shows at `flag_tx` in the same cycle. It also shows on `sda_oe` once the 9th falling pulse has passed. A counter that keeps running after the address byte shows only later, when the next byte changes a flag it should leave alone. The bench therefore sends a full data byte after each address phase.

// File: rtl/i2cst_pkg.sv
// Shared types for the address-phase status tracker.
// Assumes: one decode result is produced per address byte.
package i2cst_pkg;
    typedef struct packed {
        logic strobe;     // address byte is complete this cycle
        logic ext_hit;    // upper bits are all-0 or all-1
        logic match_hit;  // address equals the local address
        logic rw;         // direction bit (LSB of the byte)
    } addr_dec_t;
endpackage

// File: rtl/i2cst_bit_tracker.sv
// Counts SCL clocks of the first byte after a START and shifts in the
// received bits. It stops counting after the 9th clock until the next START.
// Assumes: scl_rise and scl_fall are single-cycle pulses, one per bus edge.
module i2cst_bit_tracker #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_in,
    output logic [BYTE_BITS-1:0] byte_val,
    output logic                 byte_strobe,
    output logic                 phase_done
);
    localparam int ACK_POS = BYTE_BITS + 1;
    localparam int DONE    = BYTE_BITS + 2;
    localparam int CW      = $clog2(DONE + 1);

    logic [CW-1:0]        cnt;
    logic [BYTE_BITS-2:0] shreg;
    logic                 in_byte;

    assign in_byte = (cnt != '0) && (cnt <= CW'(BYTE_BITS));

    // Clock counter: 0 = idle, 1..9 = current clock, DONE = byte finished
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || ev_stop)
            cnt <= '0;
        else if (ev_start)
            cnt <= CW'(1);
        else if (scl_fall && cnt != '0 && cnt <= CW'(ACK_POS))
            cnt <= cnt + CW'(1);
    end

    // Shift register collects the data bits, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (scl_rise && in_byte)
            shreg <= {shreg[BYTE_BITS-3:0], sda_in};
    end

    assign byte_val    = {shreg, sda_in};
    assign byte_strobe = enable && !ev_start && !ev_stop && scl_rise && (cnt == CW'(BYTE_BITS));
    assign phase_done  = (cnt == CW'(DONE));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_done && enable && !ev_start && !ev_stop) |=> phase_done);
endmodule

// File: rtl/i2cst_addr_decode.sv
// Decodes a complete address byte: extension-code pattern, local-address
// compare and direction bit.
// Assumes: byte_val is valid in the cycle byte_strobe is high.
module i2cst_addr_decode
    import i2cst_pkg::*;
#(
    parameter int ADDR_BITS = 7,
    parameter int EXT_BITS  = 4
) (
    input  logic [ADDR_BITS:0]   byte_val,
    input  logic                 byte_strobe,
    input  logic [ADDR_BITS-1:0] local_addr,
    output addr_dec_t            dec
);
    logic [EXT_BITS-1:0] upper;

    // Combinational compare of the assembled byte
    always_comb begin
        upper         = byte_val[ADDR_BITS -: EXT_BITS];
        dec.strobe    = byte_strobe;
        dec.ext_hit   = byte_strobe && ((&upper) || !(|upper));
        dec.match_hit = byte_strobe && (byte_val[ADDR_BITS:1] == local_addr);
        dec.rw        = byte_val[0];
    end
endmodule

// File: rtl/i2cst_flag_regs.sv
// Holds the extension, match and transmit flags with their set and clear
// rules. A clear always wins over a set in the same cycle.
// Assumes: event inputs are single-cycle pulses; arb_lost and enable are levels.
module i2cst_flag_regs
    import i2cst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      is_master,
    input  logic      ev_start,
    input  logic      ev_stop,
    input  logic      exit_req,
    input  logic      wait_release,
    input  logic      arb_lost,
    input  addr_dec_t dec,
    output logic      flag_ext,
    output logic      flag_match,
    output logic      flag_tx
);
    logic en_q, arb_q;
    logic en_fall, arb_rise, comm_clr;
    logic ext_d, match_d, tx_d, tx_set, tx_clr, dir_clr;

    // Edge detectors for the enable and arbitration-lost levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            arb_q <= 1'b0;
        end else begin
            en_q  <= enable;
            arb_q <= arb_lost;
        end
    end

    assign en_fall  = en_q && !enable;
    assign arb_rise = arb_lost && !arb_q;
    assign comm_clr = ev_start || ev_stop || exit_req || en_fall;

    // Next state of the address flags; a clear beats the decode set
    always_comb begin
        ext_d   = comm_clr ? 1'b0 : (dec.ext_hit   ? 1'b1 : flag_ext);
        match_d = comm_clr ? 1'b0 : (dec.match_hit ? 1'b1 : flag_match);
    end

    // Next state of the direction flag with separate master and slave rules
    always_comb begin
        tx_set  = (is_master && ev_start && enable) ||
                  (!is_master && dec.strobe && dec.rw && (ext_d || match_d));
        dir_clr = dec.strobe && (is_master ? dec.rw : !dec.rw);
        tx_clr  = ev_stop || exit_req || en_fall || wait_release || arb_rise ||
                  dir_clr || (!is_master && ev_start) ||
                  (!is_master && !ext_d && !match_d);
        tx_d    = tx_clr ? 1'b0 : (tx_set ? 1'b1 : flag_tx);
    end

    // Flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ext   <= 1'b0;
            flag_match <= 1'b0;
            flag_tx    <= 1'b0;
        end else begin
            flag_ext   <= ext_d;
            flag_match <= match_d;
            flag_tx    <= tx_d;
        end
    end

    // R4
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (!flag_ext && !flag_match));
    // R4
    exit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (!flag_ext && !flag_match && !flag_tx));
    // R8
    stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop || wait_release) |=> !flag_tx);
endmodule

// File: rtl/i2c_addr_status.sv
// Top of the address-phase status tracker. It connects the bit tracker,
// the address decoder and the flag registers, and gates the SDA driver
// enable with the transmit flag.
// Assumes: the bus front end gives single-cycle START, STOP and SCL-edge pulses.
module i2c_addr_status
    import i2cst_pkg::*;
#(
    parameter int ADDR_BITS = 7,
    parameter int EXT_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 is_master,
    input  logic [ADDR_BITS-1:0] local_addr,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_in,
    input  logic                 arb_lost,
    input  logic                 exit_req,
    input  logic                 wait_release,
    output logic                 flag_ext,
    output logic                 flag_match,
    output logic                 flag_tx,
    output logic                 sda_oe
);
    localparam int BYTE_BITS = ADDR_BITS + 1;

    logic [BYTE_BITS-1:0] byte_val;
    logic                 byte_strobe, phase_done;
    addr_dec_t            dec;

    i2cst_bit_tracker #(.BYTE_BITS(BYTE_BITS)) u_track (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .byte_val(byte_val), .byte_strobe(byte_strobe), .phase_done(phase_done)
    );

    i2cst_addr_decode #(.ADDR_BITS(ADDR_BITS), .EXT_BITS(EXT_BITS)) u_dec (
        .byte_val(byte_val), .byte_strobe(byte_strobe),
        .local_addr(local_addr), .dec(dec)
    );

    i2cst_flag_regs u_flags (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .ev_start(ev_start), .ev_stop(ev_stop), .exit_req(exit_req),
        .wait_release(wait_release), .arb_lost(arb_lost), .dec(dec),
        .flag_ext(flag_ext), .flag_match(flag_match), .flag_tx(flag_tx)
    );

    // Driver enable: transmit status after the first byte's 9th clock
    assign sda_oe = flag_tx && phase_done;

    // R9
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> ($past(scl_fall) && flag_tx));
endmodule

// File: tb/i2c_addr_status_test.sv
module i2c_addr_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, is_master = 1'b0;
    logic [6:0] local_addr = 7'h52;
    logic ev_start = 0, ev_stop = 0, scl_rise = 0, scl_fall = 0, sda_in = 0;
    logic arb_lost = 0, exit_req = 0, wait_release = 0;
    logic flag_ext, flag_match, flag_tx, sda_oe;
    int total = 0, bad = 0, cycles = 0;

    always #4 clk = ~clk;

    i2c_addr_status uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .local_addr(local_addr), .ev_start(ev_start), .ev_stop(ev_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .arb_lost(arb_lost), .exit_req(exit_req), .wait_release(wait_release),
        .flag_ext(flag_ext), .flag_match(flag_match), .flag_tx(flag_tx),
        .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic flags(input string req, input logic e, input logic m, input logic t, input logic o);
        chk(req, "flag_ext", flag_ext, e);
        chk(req, "flag_match", flag_match, m);
        chk(req, "flag_tx", flag_tx, t);
        chk(req, "sda_oe", sda_oe, o);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        ev_start = 1; tick(); ev_start = 0;
    endtask

    task automatic pulse_stop();
        ev_stop = 1; tick(); ev_stop = 0;
    endtask

    // One SCL clock: rising pulse with the data bit, then falling pulse
    task automatic clk_bit(input logic b, input logic wrel_at_rise);
        sda_in = b; scl_rise = 1; wait_release = wrel_at_rise; tick();
        scl_rise = 0; wait_release = 0; scl_fall = 1; tick();
        scl_fall = 0;
    endtask

    // Eight data clocks, MSB first; optional wait release on the 8th rise
    task automatic send_byte(input logic [7:0] v, input logic wrel8);
        for (int i = 7; i >= 0; i--) clk_bit(v[i], (i == 0) && wrel8);
    endtask

    task automatic t_reset();
        rst_n = 0; enable = 1; tick(); tick();
        flags("R1", 0, 0, 0, 0);
        rst_n = 1; tick();
    endtask

    task automatic t_master_write();
        is_master = 1; pulse_start();
        chk("R5", "tx after start", flag_tx, 1);
        send_byte(8'hA0, 0);
        flags("R5", 0, 0, 1, 0);
        sda_in = 1; scl_rise = 1; tick(); scl_rise = 0;
        chk("R9", "oe before 9th fall", sda_oe, 0);
        scl_fall = 1; tick(); scl_fall = 0;
        chk("R9", "oe after 9th fall", sda_oe, 1);
        pulse_stop();
        flags("R8", 0, 0, 0, 0);
    endtask

    task automatic t_master_read();
        is_master = 1; pulse_start();
        send_byte(8'hA1, 0);
        chk("R5", "tx after read bit", flag_tx, 0);
        pulse_stop();
    endtask

    task automatic t_slave_read();
        is_master = 0; pulse_start();
        chk("R6", "tx after slave start", flag_tx, 0);
        send_byte(8'hA5, 0);
        flags("R3", 0, 1, 1, 0);
        clk_bit(1'b0, 0);
        chk("R9", "slave oe after 9th", sda_oe, 1);
        wait_release = 1; tick(); wait_release = 0;
        chk("R8", "tx after wait release", flag_tx, 0);
        chk("R9", "oe after wait release", sda_oe, 0);
        chk("R3", "match kept", flag_match, 1);
        pulse_start();
        chk("R4", "match after start", flag_match, 0);
        pulse_stop();
    endtask

    task automatic t_slave_write_then_data();
        is_master = 0; pulse_start();
        send_byte(8'hA4, 0);
        flags("R6", 0, 1, 0, 0);
        clk_bit(1'b0, 0);
        send_byte(8'h01, 0);   // would be an extension code with read bit
        clk_bit(1'b0, 0);
        flags("R11", 0, 1, 0, 0);
        pulse_start();
        send_byte(8'h36, 0);
        chk("R4", "match after new unmatched byte", flag_match, 0);
        pulse_stop();
    endtask

    task automatic t_slave_ext();
        is_master = 0; pulse_start();
        send_byte(8'h01, 0);
        flags("R2", 1, 0, 1, 0);
        exit_req = 1; tick(); exit_req = 0;
        flags("R4", 0, 0, 0, 0);
        pulse_start();
        send_byte(8'hF2, 0);
        flags("R2", 1, 0, 0, 0);
        pulse_stop();
        chk("R4", "ext after stop", flag_ext, 0);
    endtask

    task automatic t_unaddressed();
        is_master = 0; pulse_start();
        send_byte(8'h37, 0);
        flags("R7", 0, 0, 0, 0);
        clk_bit(1'b0, 0);
        chk("R7", "oe unaddressed", sda_oe, 0);
        pulse_stop();
    endtask

    task automatic t_arb();
        is_master = 1; pulse_start();
        arb_lost = 1; tick();
        chk("R8", "tx after arb loss", flag_tx, 0);
        tick(); arb_lost = 0; tick();
        pulse_stop();
    endtask

    task automatic t_en_fall();
        is_master = 0; pulse_start();
        send_byte(8'hF1, 0);
        flags("R2", 1, 0, 1, 0);
        enable = 0; tick();
        flags("R8", 0, 0, 0, 0);
        enable = 1; tick();
    endtask

    task automatic t_clear_wins();
        is_master = 0; pulse_start();
        send_byte(8'hA5, 1);
        chk("R10", "tx with wrel at set", flag_tx, 0);
        chk("R10", "match unaffected", flag_match, 1);
        is_master = 1; ev_start = 1; ev_stop = 1; tick();
        ev_start = 0; ev_stop = 0;
        chk("R10", "tx start+stop", flag_tx, 0);
        tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        tick();
        t_reset();
        t_master_write();
        t_master_read();
        t_slave_read();
        t_slave_write_then_data();
        t_slave_ext();
        t_unaddressed();
        t_arb();
        t_en_fall();
        t_clear_wins();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule